// File: doc/BRIEF.md
# Doorbell Mailbox with Paired Circular Buffers

This block links a host and an embedded controller through two word-wide rings, one per direction. The host reaches the block through a small register port with four word addresses. It pushes words toward the controller by writing a push window (address 0) and takes the controller's words by reading a pop window (address 3). It controls the link and reads the host-to-controller ring's pointers through its own control/status word (address 1). The controller-to-host ring's pointers and the controller's ready flag appear in a read-only controller status word (address 2). The controller side has direct strobes: push, pop, and a control write that carries its ready flag and a doorbell.

A doorbell in either direction raises attention on the other side. A host doorbell is a one-cycle pulse toward the controller. A controller doorbell, or any change of the controller's ready flag, latches a pending status bit on the host side; when enabled, that bit drives the host interrupt line. The host can put both rings into a reset state with a reset bit. A reset is done as two writes, each ringing the doorbell: the first sets the reset bit, the second clears it. The link counts as up only while the host-ready and controller-ready flags are both set.

Top module: `mbox_doorbell`

## Requirements
- R1: The host control word (address 1) has this layout: bits 31:24 ring depth in slots (8 by default, fixed), 23:16 host-to-controller write pointer, 15:8 its read pointer, bit 6 overflow, bit 5 error, bit 4 reset, bit 3 host ready, bit 2 doorbell, bit 1 interrupt status, bit 0 interrupt enable. The controller status word (address 2) holds the depth, the controller-to-host write and read pointers in the same fields, and controller ready in bit 3. After reset both words read 0x08000000. Reading address 0 returns zero.
- R2: Each host write to address 0 stores one word and advances the write pointer by one, modulo 256. The controller sees the oldest stored word on c_rdata, and each c_pop removes that word and advances the read pointer. Words come out in the order they were pushed.
- R3: The occupied count of a ring is (write pointer − read pointer) mod 256. It stays correct across pointer wrap and never exceeds the depth. Overflow bit 6 flags a count above the depth and therefore reads 0. c_h2c_fill shows the host-to-controller count.
- R4: A push into a full ring is dropped: the write pointer does not change and the word is not stored. A controller pop of an empty ring is dropped as well and c_rdata shows zero. Only the host's dropped pushes and pops set error bit 5; the controller's drops do not.
- R5: A host read returns its data on h_rdata in the cycle after the read strobe. A read of address 3 pops the oldest controller-to-host word. A read of address 3 on an empty ring returns zero, leaves the pointers unchanged and sets the sticky error bit 5. Writing a one to bit 5 clears it.
- R6: Interrupt status (bit 1) is set by a controller control write with its doorbell set, and by any change of the controller-ready flag. A host write with a one in bit 1 clears it. A host write with bit 1 at zero leaves it unchanged. A new set event wins over a clear in the same cycle.
- R7: h_irq is high exactly when both interrupt status and interrupt enable are set.
- R8: A host write with a one in bit 2 produces a single-cycle c_doorbell pulse in the cycle after the write. Bit 2 always reads zero.
- R9: While reset bit 4 is set, both rings' pointers are held at zero and pushes are ignored. The host-ready and controller-ready flags are cleared, and a controller ready write is ignored. c_host_rst shows bit 4.
- R10: link_up is high exactly when host ready and controller ready are both set. c_host_rdy shows host ready.
- R11: The reset handshake is two host writes. The first (reset and doorbell set) gives a c_doorbell pulse with c_host_rst high and then empty rings. The second (reset clear, doorbell and ready set) gives a second pulse with c_host_rst low and host ready set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host word address (0 push, 1 control, 2 controller status, 3 pop) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_rd |
| h_irq | output | 1 | Host interrupt |
| c_push | input | 1 | Controller push into controller-to-host ring |
| c_wdata | input | 32 | Controller push data |
| c_pop | input | 1 | Controller pop from host-to-controller ring |
| c_rdata | output | 32 | Oldest host-to-controller word, zero when empty |
| c_h2c_fill | output | 8 | Host-to-controller occupied count |
| c_c2h_full | output | 1 | Controller-to-host ring full |
| c_ctl_wr | input | 1 | Controller control write strobe |
| c_ctl_ready | input | 1 | Controller ready value for the control write |
| c_ctl_ring | input | 1 | Controller doorbell with the control write |
| c_doorbell | output | 1 | One-cycle host doorbell pulse |
| c_host_rst | output | 1 | Host reset bit |
| c_host_rdy | output | 1 | Host ready bit |
| link_up | output | 1 | Both sides ready |

## Verification
All state changes at the edge that samples a strobe. A host read value is due one cycle after h_rd. Pointers, error, status, h_irq and c_doorbell change one cycle after the write or controller strobe that causes them. Ring flushing lags the reset bit by one further cycle. The bench drives strobes for exactly one cycle from the falling edge and samples at the next falling edge, once the causing edge has passed. For reset effects it reads the words back through a later host read, which falls after the flush cycle. c_rdata is combinational from the head and is sampled before the pop that consumes it.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the doorbell mailbox.
// Assumes 8-bit pointers on every ring, as laid out in the status words.
package mbox_pkg;
    localparam int PTR_W  = 8;
    localparam int WORD_W = 32;

    localparam int BIT_IEN  = 0;
    localparam int BIT_STS  = 1;
    localparam int BIT_RING = 2;
    localparam int BIT_RDY  = 3;
    localparam int BIT_RST  = 4;
    localparam int BIT_ERR  = 5;
    localparam int BIT_OVF  = 6;
    localparam int CSR_WD_W = 6;

    typedef enum logic [1:0] {
        A_PUSH  = 2'd0,
        A_HCSR  = 2'd1,
        A_CSTAT = 2'd2,
        A_POP   = 2'd3
    } mbox_addr_e;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] fill;
        logic             full;
        logic             empty;
        logic             ovf;
    } ring_stat_t;
endpackage

// File: rtl/mbox_ring.sv
// One word-wide circular buffer with free-running 8-bit pointers.
// The storage index is the low DEPTH_LOG2 pointer bits, and the fill is the
// modulo-256 difference of the pointers. Pushes into a full ring and pops from
// an empty ring are dropped. Flush holds both pointers at zero.
// Assumes a power-of-two depth of at most 128 slots.
module mbox_ring
    import mbox_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output ring_stat_t        stat,
    output logic              push_drop,
    output logic              pop_drop
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [PTR_W-1:0] DEPTH_B = PTR_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [PTR_W-1:0]  fill;
    logic              full, empty, push_ok, pop_ok;

    // Occupancy from the pointer difference.
    always_comb begin
        fill  = wptr_q - rptr_q;
        full  = (fill >= DEPTH_B);
        empty = (fill == '0);
    end

    // Accept or drop each strobe.
    always_comb begin
        push_ok   = push && !full && !flush;
        pop_ok    = pop && !empty && !flush;
        push_drop = push && full && !flush;
        pop_drop  = pop && empty && !flush;
    end

    // Pointer registers, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= rptr_q + 1'b1;
        end
    end

    // Word storage, written on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q[DEPTH_LOG2-1:0]] <= wdata;
    end

    // Oldest word, or zero when nothing is stored.
    always_comb begin
        head = empty ? '0 : mem[rptr_q[DEPTH_LOG2-1:0]];
    end

    // Status bundle.
    always_comb begin
        stat.wptr  = wptr_q;
        stat.rptr  = rptr_q;
        stat.fill  = fill;
        stat.full  = full;
        stat.empty = empty;
        stat.ovf   = (fill > DEPTH_B);
    end
endmodule

// File: rtl/mbox_ctrl_rdy.sv
// Controller ready flag and the event that latches host interrupt status.
// The flag follows controller control writes and is forced clear while the
// host reset bit is set. The event fires on a controller doorbell or on any
// change of the flag.
module mbox_ctrl_rdy (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst,
    input  logic c_ctl_wr,
    input  logic c_ctl_ready,
    input  logic c_ctl_ring,
    output logic ctrl_rdy,
    output logic ctrl_evt
);
    logic rdy_q, rdy_d;

    // Next value of the ready flag.
    always_comb begin
        if (host_rst)      rdy_d = 1'b0;
        else if (c_ctl_wr) rdy_d = c_ctl_ready;
        else               rdy_d = rdy_q;
    end

    // Ready flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= rdy_d;
    end

    // Doorbell or ready change toward the host.
    always_comb begin
        ctrl_evt = (c_ctl_wr && c_ctl_ring) || (rdy_d != rdy_q);
        ctrl_rdy = rdy_q;
    end
endmodule

// File: rtl/mbox_host_if.sv
// Host register port: decodes strobes, holds the host control bits, and
// returns registered read data one cycle after the read strobe.
// Interrupt status and error are write-one-to-clear, and a set event wins
// over a clear. The doorbell bit gives a registered one-cycle pulse.
module mbox_host_if
    import mbox_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_wr,
    input  logic                h_rd,
    input  logic [1:0]          h_addr,
    input  logic [CSR_WD_W-1:0] csr_wd,
    input  ring_stat_t          h2c_stat,
    input  ring_stat_t          c2h_stat,
    input  logic [WORD_W-1:0]   c2h_head,
    input  logic                h2c_push_drop,
    input  logic                c2h_pop_drop,
    input  logic                ctrl_evt,
    input  logic                ctrl_rdy,
    output logic                h2c_push,
    output logic                c2h_pop,
    output logic [WORD_W-1:0]   h_rdata,
    output logic                host_rst,
    output logic                host_rdy,
    output logic                host_sts,
    output logic                host_ien,
    output logic                host_err,
    output logic                doorbell_q
);
    localparam logic [7:0] DEPTH_B = 8'(1 << DEPTH_LOG2);

    logic              wr_csr;
    logic [WORD_W-1:0] csr_word, cstat_word;

    // Strobe decode.
    always_comb begin
        wr_csr   = h_wr && (h_addr == A_HCSR);
        h2c_push = h_wr && (h_addr == A_PUSH);
        c2h_pop  = h_rd && (h_addr == A_POP);
    end

    // Host control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ien   <= 1'b0;
            host_rst   <= 1'b0;
            host_rdy   <= 1'b0;
            doorbell_q <= 1'b0;
        end else begin
            doorbell_q <= wr_csr && csr_wd[BIT_RING];
            if (wr_csr) begin
                host_ien <= csr_wd[BIT_IEN];
                host_rst <= csr_wd[BIT_RST];
                host_rdy <= csr_wd[BIT_RDY] && !csr_wd[BIT_RST];
            end else if (host_rst) begin
                host_rdy <= 1'b0;
            end
        end
    end

    // Write-one-to-clear status and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_sts <= 1'b0;
            host_err <= 1'b0;
        end else begin
            host_sts <= (host_sts && !(wr_csr && csr_wd[BIT_STS])) || ctrl_evt;
            host_err <= (host_err && !(wr_csr && csr_wd[BIT_ERR]))
                        || h2c_push_drop || c2h_pop_drop;
        end
    end

    // Assemble the two status words.
    always_comb begin
        csr_word = {DEPTH_B, h2c_stat.wptr, h2c_stat.rptr, 1'b0, h2c_stat.ovf,
                    host_err, host_rst, host_rdy, 1'b0, host_sts, host_ien};
        cstat_word = {DEPTH_B, c2h_stat.wptr, c2h_stat.rptr, 1'b0, c2h_stat.ovf,
                      2'b00, ctrl_rdy, 3'b000};
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
        end else if (h_rd) begin
            case (h_addr)
                A_HCSR:  h_rdata <= csr_word;
                A_CSTAT: h_rdata <= cstat_word;
                A_POP:   h_rdata <= c2h_head;
                default: h_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_doorbell.sv
// Top of the doorbell mailbox: two rings, the host register port and the
// controller ready logic. Both rings are flushed while the host reset bit is
// set. Only the host's dropped accesses set the sticky error.
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [1:0]        h_addr,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              c_push,
    input  logic [WORD_W-1:0] c_wdata,
    input  logic              c_pop,
    output logic [WORD_W-1:0] c_rdata,
    output logic [PTR_W-1:0]  c_h2c_fill,
    output logic              c_c2h_full,
    input  logic              c_ctl_wr,
    input  logic              c_ctl_ready,
    input  logic              c_ctl_ring,
    output logic              c_doorbell,
    output logic              c_host_rst,
    output logic              c_host_rdy,
    output logic              link_up
);
    ring_stat_t        h2c_stat, c2h_stat;
    logic [WORD_W-1:0] c2h_head;
    logic              h2c_push, c2h_pop;
    logic              h2c_push_drop, h2c_pop_drop, c2h_push_drop, c2h_pop_drop;
    logic              host_rst, host_rdy, host_sts, host_ien, host_err;
    logic              ctrl_rdy, ctrl_evt;

    mbox_ring #(.DEPTH_LOG2(DEPTH_LOG2)) u_h2c (
        .clk(clk), .rst_n(rst_n), .flush(host_rst),
        .push(h2c_push), .wdata(h_wdata), .pop(c_pop),
        .head(c_rdata), .stat(h2c_stat),
        .push_drop(h2c_push_drop), .pop_drop(h2c_pop_drop)
    );

    mbox_ring #(.DEPTH_LOG2(DEPTH_LOG2)) u_c2h (
        .clk(clk), .rst_n(rst_n), .flush(host_rst),
        .push(c_push), .wdata(c_wdata), .pop(c2h_pop),
        .head(c2h_head), .stat(c2h_stat),
        .push_drop(c2h_push_drop), .pop_drop(c2h_pop_drop)
    );

    mbox_ctrl_rdy u_crdy (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
        .c_ctl_wr(c_ctl_wr), .c_ctl_ready(c_ctl_ready), .c_ctl_ring(c_ctl_ring),
        .ctrl_rdy(ctrl_rdy), .ctrl_evt(ctrl_evt)
    );

    mbox_host_if #(.DEPTH_LOG2(DEPTH_LOG2)) u_host (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .csr_wd(h_wdata[CSR_WD_W-1:0]), .h2c_stat(h2c_stat), .c2h_stat(c2h_stat),
        .c2h_head(c2h_head), .h2c_push_drop(h2c_push_drop),
        .c2h_pop_drop(c2h_pop_drop), .ctrl_evt(ctrl_evt), .ctrl_rdy(ctrl_rdy),
        .h2c_push(h2c_push), .c2h_pop(c2h_pop), .h_rdata(h_rdata),
        .host_rst(host_rst), .host_rdy(host_rdy), .host_sts(host_sts),
        .host_ien(host_ien), .host_err(host_err), .doorbell_q(c_doorbell)
    );

    // Controller-side drops are silent by design; they only feed the checker.
    // Interrupt, link and mirrored outputs.
    always_comb begin
        h_irq      = host_sts && host_ien;
        link_up    = host_rdy && ctrl_rdy;
        c_host_rst = host_rst;
        c_host_rdy = host_rdy;
        c_h2c_fill = h2c_stat.fill;
        c_c2h_full = c2h_stat.full;
    end
endmodule

// File: rtl/mbox_doorbell_chk.sv
// Temporal checks on the mailbox, bound into the top module.
module mbox_doorbell_chk
    import mbox_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic              h_rd,
    input logic [1:0]        h_addr,
    input logic [WORD_W-1:0] h_wdata,
    input logic [WORD_W-1:0] h_rdata,
    input logic              c_pop,
    input logic              c_ctl_wr,
    input logic              c_ctl_ring,
    input logic              c_doorbell,
    input ring_stat_t        h2c_stat,
    input ring_stat_t        c2h_stat,
    input logic              host_sts,
    input logic              host_rst,
    input logic              ctrl_rdy,
    input logic              h2c_pop_drop,
    input logic              c2h_push_drop
);
    localparam logic [PTR_W-1:0] DEPTH_B = PTR_W'(1 << DEPTH_LOG2);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h2c_stat.fill <= DEPTH_B) && (c2h_stat.fill <= DEPTH_B));

    // R4
    push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == A_PUSH && h2c_stat.full && !host_rst) |=> $stable(h2c_stat.wptr));

    // R4
    ctrl_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pop && h2c_stat.empty && !host_rst) |=> $stable(h2c_stat.rptr));

    // R4
    ctrl_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c2h_push_drop |=> $stable(c2h_stat.wptr));

    // R5
    pop_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_addr == A_POP && c2h_stat.empty && !host_rst)
        |=> (h_rdata == '0) && $stable(c2h_stat.rptr));

    // R6
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == A_HCSR && !h_wdata[BIT_STS] && host_sts) |=> host_sts);

    // R6
    ring_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ctl_wr && c_ctl_ring) |=> host_sts);

    // R8
    doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_doorbell |-> $past(h_wr && h_addr == A_HCSR && h_wdata[BIT_RING]));

    // R9
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (h2c_stat.wptr == '0) && (h2c_stat.rptr == '0)
                     && (c2h_stat.wptr == '0) && (c2h_stat.rptr == '0) && !ctrl_rdy);

    // R9
    reset_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |-> !h2c_pop_drop);
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .c_pop(c_pop), .c_ctl_wr(c_ctl_wr),
    .c_ctl_ring(c_ctl_ring), .c_doorbell(c_doorbell), .h2c_stat(h2c_stat),
    .c2h_stat(c2h_stat), .host_sts(host_sts), .host_rst(host_rst),
    .ctrl_rdy(ctrl_rdy), .h2c_pop_drop(h2c_pop_drop), .c2h_push_drop(c2h_push_drop)
);

// File: tb/mbox_doorbell_test.sv
// Self-checking bench for the doorbell mailbox at depth 8.
module mbox_doorbell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 1'b0, h_rd = 1'b0;
    logic [1:0]  h_addr = 2'd0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_irq;
    logic        c_push = 1'b0, c_pop = 1'b0;
    logic [31:0] c_wdata = '0;
    logic [31:0] c_rdata;
    logic [7:0]  c_h2c_fill;
    logic        c_c2h_full;
    logic        c_ctl_wr = 1'b0, c_ctl_ready = 1'b0, c_ctl_ring = 1'b0;
    logic        c_doorbell, c_host_rst, c_host_rdy, link_up;

    int nchk = 0;
    int nerr = 0;
    int hw_w = 0;
    int hw_r = 0;

    mbox_doorbell #(.DEPTH_LOG2(3)) uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int w, input int r, input bit err,
                                         input bit rst, input bit rdy, input bit sts,
                                         input bit ien);
        return {8'd8, 8'(w), 8'(r), 2'b00, err, rst, rdy, 1'b0, sts, ien};
    endfunction

    task automatic hwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); h_rd = 1'b1; h_addr = a;
        @(negedge clk); h_rd = 1'b0; d = h_rdata;
    endtask

    task automatic cpush(input logic [31:0] d);
        @(negedge clk); c_push = 1'b1; c_wdata = d;
        @(negedge clk); c_push = 1'b0;
    endtask

    task automatic cpop(output logic [31:0] d);
        @(negedge clk); d = c_rdata; c_pop = 1'b1;
        @(negedge clk); c_pop = 1'b0;
    endtask

    task automatic cctl(input bit rdy, input bit ring);
        @(negedge clk); c_ctl_wr = 1'b1; c_ctl_ready = rdy; c_ctl_ring = ring;
        @(negedge clk); c_ctl_wr = 1'b0; c_ctl_ring = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        hrd(2'd1, d); chk("R1 host word after reset", d, 32'h0800_0000);
        hrd(2'd2, d); chk("R1 ctrl word after reset", d, 32'h0800_0000);
        hrd(2'd0, d); chk("R1 push window reads zero", d, 32'h0);
        chk("R7 irq after reset", {31'd0, h_irq}, 32'd0);
        chk("R10 link after reset", {31'd0, link_up}, 32'd0);

        // R2 R4 fill sweep past full
        for (int i = 1; i <= 10; i++) begin
            hwr(2'd0, 32'hA000_0000 + i);
            if (i <= 8) hw_w++;
            chk("R3 fill during sweep", {24'd0, c_h2c_fill}, 32'(hw_w));
            hrd(2'd1, d);
            chk("R4 host word during sweep", d, word(hw_w, 0, i > 8, 0, 0, 0, 0));
        end
        for (int i = 1; i <= 8; i++) begin
            cpop(d); hw_r++;
            chk("R2 pop order", d, 32'hA000_0000 + i);
        end
        cpop(d); chk("R4 ctrl pop of empty is zero", d, 32'h0);
        hrd(2'd1, d); chk("R4 ctrl drop leaves pointers", d, word(8, 8, 1, 0, 0, 0, 0));
        hwr(2'd1, 32'h20);
        hrd(2'd1, d); chk("R5 error cleared by one", d, word(8, 8, 0, 0, 0, 0, 0));

        // R3 pointer wrap sweep
        for (int n = 0; n < 500; n++) begin
            hwr(2'd0, 32'h5000_0000 ^ n); hw_w++;
            if (c_h2c_fill !== 8'd1) chk("R3 fill one in wrap sweep", {24'd0, c_h2c_fill}, 32'd1);
            cpop(d); hw_r++;
            if (d !== (32'h5000_0000 ^ n)) chk("R2 data in wrap sweep", d, 32'h5000_0000 ^ n);
        end
        nchk++;
        hrd(2'd1, d); chk("R3 pointers after wrap", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 0, 0));
        for (int i = 0; i < 9; i++) begin
            hwr(2'd0, 32'hC000_0000 + i);
            if (i < 8) hw_w++;
        end
        chk("R3 full across wrap", {24'd0, c_h2c_fill}, 32'd8);
        hrd(2'd1, d); chk("R4 drop across wrap", d, word(hw_w % 256, hw_r % 256, 1, 0, 0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            cpop(d); hw_r++;
            chk("R2 data after wrap", d, 32'hC000_0000 + i);
        end
        hwr(2'd1, 32'h20);

        // R5 controller-to-host ring
        for (int i = 0; i < 9; i++) cpush(32'hD000_0000 + i);
        chk("R4 ctrl ring full", {31'd0, c_c2h_full}, 32'd1);
        hrd(2'd1, d); chk("R4 ctrl push drop no error", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 0, 0));
        hrd(2'd2, d); chk("R1 ctrl word pointers", d, word(8, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            hrd(2'd3, d); chk("R5 host pop data", d, 32'hD000_0000 + i);
        end
        hrd(2'd3, d); chk("R5 host pop empty zero", d, 32'h0);
        hrd(2'd2, d); chk("R5 empty pop leaves pointers", d, word(8, 8, 0, 0, 0, 0, 0));
        hrd(2'd1, d); chk("R5 empty pop sets error", d, word(hw_w % 256, hw_r % 256, 1, 0, 0, 0, 0));
        hwr(2'd1, 32'h20);

        // R6 R7 interrupts
        hwr(2'd1, 32'h1);
        cctl(0, 1);
        chk("R7 irq on doorbell", {31'd0, h_irq}, 32'd1);
        hrd(2'd1, d); chk("R6 status set", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 1, 1));
        hwr(2'd1, 32'h1);
        chk("R6 zero write keeps status", {31'd0, h_irq}, 32'd1);
        hwr(2'd1, 32'h3);
        chk("R6 one write clears status", {31'd0, h_irq}, 32'd0);
        cctl(0, 1);
        hwr(2'd1, 32'h0);
        chk("R7 irq masked", {31'd0, h_irq}, 32'd0);
        hrd(2'd1, d); chk("R7 status pending while masked", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 1, 0));
        hwr(2'd1, 32'h2);
        cctl(1, 0);
        hrd(2'd1, d); chk("R6 ready change sets status", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 1, 0));
        hrd(2'd2, d); chk("R1 ctrl ready bit", d, word(8, 8, 0, 0, 1, 0, 0));
        hwr(2'd1, 32'h2);
        cctl(1, 0);
        hrd(2'd1, d); chk("R6 unchanged ready no status", d, word(hw_w % 256, hw_r % 256, 0, 0, 0, 0, 0));

        // R10 link and R8 doorbell
        chk("R10 link needs host ready", {31'd0, link_up}, 32'd0);
        hwr(2'd1, 32'hC);
        chk("R8 doorbell pulse", {31'd0, c_doorbell}, 32'd1);
        chk("R10 link up", {31'd0, link_up}, 32'd1);
        chk("R10 host ready out", {31'd0, c_host_rdy}, 32'd1);
        @(negedge clk);
        chk("R8 doorbell one cycle", {31'd0, c_doorbell}, 32'd0);
        hrd(2'd1, d); chk("R8 doorbell reads zero", d, word(hw_w % 256, hw_r % 256, 0, 0, 1, 0, 0));
        cctl(0, 0);
        chk("R10 link down with ctrl", {31'd0, link_up}, 32'd0);
        cctl(1, 0);
        hwr(2'd1, 32'h2);

        // R9 R11 reset handshake
        hwr(2'd0, 32'h1111); hwr(2'd0, 32'h2222);
        cpush(32'h3333);
        hwr(2'd1, 32'h14);
        chk("R11 first doorbell", {31'd0, c_doorbell}, 32'd1);
        chk("R11 reset out high", {31'd0, c_host_rst}, 32'd1);
        chk("R9 host ready cleared", {31'd0, c_host_rdy}, 32'd0);
        hrd(2'd1, d); chk("R9 host ring held zero", {d[31:8], d[4:3]}, {8'd8, 8'd0, 8'd0, 2'b10});
        hrd(2'd2, d); chk("R9 ctrl ring and ready zero", d, 32'h0800_0000);
        chk("R9 fill zero", {24'd0, c_h2c_fill}, 32'd0);
        cctl(1, 0);
        cpush(32'h4444);
        hwr(2'd0, 32'h5555);
        hrd(2'd2, d); chk("R9 ready and push ignored", d, 32'h0800_0000);
        chk("R9 host push ignored", {24'd0, c_h2c_fill}, 32'd0);
        chk("R10 link down in reset", {31'd0, link_up}, 32'd0);
        hwr(2'd1, 32'hE);
        chk("R11 second doorbell", {31'd0, c_doorbell}, 32'd1);
        chk("R11 reset out low", {31'd0, c_host_rst}, 32'd0);
        chk("R11 host ready set", {31'd0, c_host_rdy}, 32'd1);
        cctl(1, 0);
        chk("R11 link after handshake", {31'd0, link_up}, 32'd1);
        hwr(2'd0, 32'h6666);
        cpop(d); chk("R11 ring usable after handshake", d, 32'h6666);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule